// File: doc/BRIEF.md
# PLL output rate calculator

This block computes the output frequency of a fractional-N PLL from three operands: the reference frequency, the feedback divider word and a 3-bit post-divider code. The divider word carries seven integer bits at its top; any bits below those are a binary fraction. The block multiplies reference by divider word at full width. It then drops the fraction and rounds the result upward. Last, it divides by the power-of-two post-divide ratio, again rounding upward.

A caller presents the operands with a one-cycle `start_i` pulse and takes `rate_o` when `done_o` pulses. The datapath is a two-stage pipeline, so a new start may be issued on every cycle. The divider word width is a parameter fixed at elaboration, and the output is sized so that no operand combination can overflow it.

Top module: `pll_rate_calc`

## Requirements
- R1: After reset, `done_o` is 0 and `rate_o` is 0.
- R2: With post-divider code 0 and all fractional bits of the product ref*pcw equal to zero, `rate_o` equals ref*pcw shifted right by the fraction width (PCW_W-7, or 0 when PCW_W is 7 or less).
- R3: When any of the low fraction-width bits of ref*pcw is nonzero, the intermediate VCO value is (ref*pcw >> fraction width) + 1.
- R4: The post-divide ratio is 2 raised to the code on `pd_sel_i`, for every code 0 to 7; codes 5, 6 and 7 divide by 32, 64 and 128.
- R5: The post-divide step is a ceiling: `rate_o` is the smallest integer q with q * 2^code not below the VCO value.
- R6: `done_o` is high for exactly one cycle, on the second rising edge after the edge that samples `start_i` high, and is never high otherwise.
- R7: `rate_o` changes only in a cycle where `done_o` is high, and it otherwise holds its last result.
- R8: Starts on consecutive cycles each yield their own result, in issue order, on consecutive cycles.
- R9: With all-ones reference and divider word and code 0, `rate_o` holds the full rounded VCO value with no wraparound; `rate_o` never exceeds the VCO value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request; operands are sampled with it |
| ref_i | input | REF_W | Reference frequency |
| pcw_i | input | PCW_W | Feedback divider word, 7 integer bits over the fraction |
| pd_sel_i | input | 3 | Post-divider code; ratio is 2^code |
| done_o | output | 1 | One-cycle pulse marking a fresh `rate_o` |
| rate_o | output | OUT_W | Computed output rate, held between results |

## Verification
The case that can fall in the same cycle is the hand-off of one result at the output while the next request is being accepted. The bench provokes it by issuing starts on consecutive cycles with differing operands and post-divider codes. It judges each `done_o` pulse against the expected value of the request issued two edges before. It then holds the inputs idle and confirms that the last result stays put.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
  localparam int CALC_W  = 64;
  localparam int INT_BITS = 7;
  localparam int PD_W    = 3;

  function automatic int frac_bits(input int pcw_w);
    return (pcw_w > INT_BITS) ? pcw_w - INT_BITS : 0;
  endfunction

  // ceiling of x / 2^sh, computed as add-then-shift
  function automatic logic [CALC_W-1:0] pow2_ceil(input logic [CALC_W-1:0] x,
                                                  input int unsigned sh);
    logic [CALC_W-1:0] bias;
    bias = (CALC_W'(1) << sh) - CALC_W'(1);
    return (x + bias) >> sh;
  endfunction
endpackage

// File: rtl/pll_vco_stage.sv
module pll_vco_stage #(
  parameter int REF_W = 32,
  parameter int PCW_W = 22,
  parameter int FRAC_W = 15,
  parameter int VCO_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [PCW_W-1:0] pcw_i,
  input  logic [2:0]       pd_i,
  output logic             vld_o,
  output logic [VCO_W-1:0] vco_o,
  output logic [2:0]       pd_o
);
  localparam int PROD_W = REF_W + PCW_W;

  logic [PROD_W-1:0] prod;
  logic [VCO_W-1:0]  vco_next;
  logic              frac_nz;

  assign prod = PROD_W'(ref_i) * PROD_W'(pcw_i);

  generate
    if (FRAC_W > 0) begin : g_frac
      assign frac_nz  = |prod[FRAC_W-1:0];
      assign vco_next = VCO_W'(prod[PROD_W-1:FRAC_W]) + VCO_W'(frac_nz);
    end else begin : g_int
      assign frac_nz  = 1'b0;
      assign vco_next = VCO_W'(prod);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      vco_o <= '0;
      pd_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        vco_o <= vco_next;
        pd_o  <= pd_i;
      end
    end
  end

  // R3: a rounded-up value never falls below the truncated product
  a_r3_round_floor: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (vco_o >= VCO_W'($past(prod) >> FRAC_W)));
endmodule

// File: rtl/pll_postdiv_stage.sv
module pll_postdiv_stage #(
  parameter int VCO_W = 40,
  parameter int OUT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [VCO_W-1:0] vco_i,
  input  logic [2:0]       pd_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] rate_o
);
  import pll_rate_pkg::*;

  logic [OUT_W-1:0] rate_next;

  assign rate_next = OUT_W'(pow2_ceil(CALC_W'(vco_i), int'(pd_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      rate_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) rate_o <= rate_next;
    end
  end

  // R9: the divided rate never exceeds the VCO value it came from
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (CALC_W'(rate_o) <= CALC_W'($past(vco_i))));

  // R5: scaling the result back up covers the VCO value
  a_r5_ceil_covers: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> ((CALC_W'(rate_o) << $past(pd_i)) >= CALC_W'($past(vco_i))));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int REF_W = 32,
  parameter int PCW_W = 22,
  localparam int FRAC_W = pll_rate_pkg::frac_bits(PCW_W),
  localparam int VCO_W = REF_W + PCW_W - FRAC_W + 1,
  localparam int OUT_W = VCO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [PCW_W-1:0] pcw_i,
  input  logic [2:0]       pd_sel_i,
  output logic             done_o,
  output logic [OUT_W-1:0] rate_o
);
  logic             vco_valid;
  logic [VCO_W-1:0] vco_val;
  logic [2:0]       vco_pd;

  pll_vco_stage #(
    .REF_W(REF_W), .PCW_W(PCW_W), .FRAC_W(FRAC_W), .VCO_W(VCO_W)
  ) u_vco (
    .clk(clk), .rst_n(rst_n), .vld_i(start_i),
    .ref_i(ref_i), .pcw_i(pcw_i), .pd_i(pd_sel_i),
    .vld_o(vco_valid), .vco_o(vco_val), .pd_o(vco_pd)
  );

  pll_postdiv_stage #(
    .VCO_W(VCO_W), .OUT_W(OUT_W)
  ) u_pdiv (
    .clk(clk), .rst_n(rst_n), .vld_i(vco_valid),
    .vco_i(vco_val), .pd_i(vco_pd),
    .vld_o(done_o), .rate_o(rate_o)
  );

  // R6: done follows a start by exactly two edges
  a_r6_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ##1 done_o);

  // R6: done only appears behind a valid middle stage
  a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(vco_valid));

  // R7: the result only moves with done
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rate_o));
endmodule

// File: tb/pll_rate_calc_bench.sv
`timescale 1ns/1ps
module pll_rate_calc_bench;
  localparam int REF_W = 32;
  localparam int PCW_W = 22;
  localparam int FRAC  = 15;
  localparam int OUT_W = 40;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [REF_W-1:0] ref_i = '0;
  logic [PCW_W-1:0] pcw_i = '0;
  logic [2:0]       pd_sel_i = '0;
  logic             done_o;
  logic [OUT_W-1:0] rate_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pll_rate_calc #(.REF_W(REF_W), .PCW_W(PCW_W)) u_pll_rate_calc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_i(ref_i),
    .pcw_i(pcw_i), .pd_sel_i(pd_sel_i), .done_o(done_o), .rate_o(rate_o)
  );

  // VCO: truncate then bump on any nonzero fraction bit
  function automatic logic [63:0] exp_vco(input logic [31:0] r, input logic [21:0] p);
    logic [63:0] prod;
    logic [63:0] q;
    prod = {32'd0, r} * {42'd0, p};
    q = prod >> FRAC;
    if ((prod & ((64'd1 << FRAC) - 64'd1)) != 64'd0) q = q + 64'd1;
    return q;
  endfunction

  function automatic logic [63:0] exp_rate(input logic [31:0] r, input logic [21:0] p,
                                           input logic [2:0] d);
    logic [63:0] v;
    logic [63:0] q;
    v = exp_vco(r, p);
    q = v >> d;
    if ((q << d) != v) q = q + 64'd1;
    return q;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic issue(input logic [31:0] r, input logic [21:0] p, input logic [2:0] d);
    start_i = 1'b1; ref_i = r; pcw_i = p; pd_sel_i = d;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one request, result checked at the negedge after the second edge
  task automatic run_one(input logic [31:0] r, input logic [21:0] p, input logic [2:0] d,
                         input string req);
    logic [63:0] e;
    e = exp_rate(r, p, d);
    issue(r, p, d);
    check(done_o == 1'b0, "R6", 64'(done_o), 64'd0);
    @(negedge clk);
    check(done_o == 1'b1, "R6", 64'(done_o), 64'd1);
    check(64'(rate_o) == e, req, 64'(rate_o), e);
    @(negedge clk);
    check(done_o == 1'b0, "R6", 64'(done_o), 64'd0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] held;
    logic [63:0] ea, eb;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    // R1
    check(done_o == 1'b0, "R1", 64'(done_o), 64'd0);
    check(rate_o == '0, "R1", 64'(rate_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: integer-only divider word, code 0
    run_one(32'd26000000, 22'(40) << FRAC, 3'd0, "R2");
    run_one(32'd1000, 22'(127) << FRAC, 3'd0, "R2");
    // R3: fraction present forces a bump
    run_one(32'd3, 22'd1, 3'd0, "R3");
    run_one(32'd26000000, 22'h0F_1234, 3'd0, "R3");
    // R4: every code including 5..7
    for (int c = 0; c < 8; c++) run_one(32'd26000000, 22'h20_0000, 3'(c), "R4");
    // R5: ceiling of post-divide with remainder
    run_one(32'd7, 22'(1) << FRAC, 3'd2, "R5");
    run_one(32'd1, 22'd1, 3'd7, "R5");
    // R9: full-scale operands
    run_one(32'hFFFF_FFFF, 22'h3F_FFFF, 3'd0, "R9");
    run_one(32'hFFFF_FFFF, 22'h3F_FFFF, 3'd7, "R9");

    // R7: result holds while idle
    held = 64'(rate_o);
    repeat (4) @(negedge clk);
    check(64'(rate_o) == held, "R7", 64'(rate_o), held);
    check(done_o == 1'b0, "R7", 64'(done_o), 64'd0);

    // R8: back-to-back starts
    for (int k = 0; k < 20; k++) begin
      logic [31:0] ra, rb;
      logic [21:0] pa, pb;
      logic [2:0]  da, db;
      ra = $urandom; rb = $urandom;
      pa = 22'($urandom); pb = 22'($urandom);
      da = 3'($urandom); db = 3'($urandom);
      ea = exp_rate(ra, pa, da);
      eb = exp_rate(rb, pb, db);
      issue(ra, pa, da);
      issue(rb, pb, db);
      check(done_o == 1'b1, "R8", 64'(done_o), 64'd1);
      check(64'(rate_o) == ea, "R8", 64'(rate_o), ea);
      @(negedge clk);
      check(done_o == 1'b1, "R8", 64'(done_o), 64'd1);
      check(64'(rate_o) == eb, "R8", 64'(rate_o), eb);
      @(negedge clk);
    end

    // random single requests, R5 ceiling across codes
    for (int k = 0; k < 300; k++) begin
      run_one($urandom, 22'($urandom), 3'($urandom), "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule